// File: doc/BRIEF.md
# Serial In-System Programming Slave

This block lets an external programmer load and inspect an on-chip nonvolatile memory model over a three-wire serial link. The model has a program array and a data array. The link is a clock (`sck`), a data input (`mosi`) and a data output (`miso`). The block works only while the device reset input `dev_rst` is held low. It does not run from the serial clock. It samples `sck` and `mosi` with its own system clock, finds the serial clock edges and assembles 32-bit instruction frames. Each frame is four bytes, most significant bit first. Input data is taken on each rising serial edge. Output data changes on each falling serial edge.

After `dev_rst` goes low, the block refuses all work until an enable frame arrives. The enable frame returns its second byte during the third byte, so the programmer can confirm that the two ends are aligned. Once enabled, the block accepts four kinds of command:

- a whole-chip erase, which walks both arrays and writes 0xFF everywhere;
- a data-array byte write, which overwrites the target byte in one step;
- a program-array byte write;
- a data-array read.

Every erase or write opens a busy window. During that window only a status poll is answered.

The control machine has five states:

- `ST_OFF`: the link is inactive.
- `ST_LOCKED`: the link is active but not yet enabled.
- `ST_READY`: the block is enabled and idle.
- `ST_ERASE`: the erase walk is running.
- `ST_WAIT`: the self-timed busy window is running.

The transitions are:

- any state goes to `ST_OFF` when the link becomes inactive;
- `ST_OFF` goes to `ST_LOCKED` when the link becomes active;
- `ST_LOCKED` goes to `ST_READY` on an enable frame;
- `ST_READY` goes to `ST_ERASE` on an erase frame;
- `ST_READY` goes to `ST_WAIT` on either write frame;
- `ST_ERASE` goes to `ST_WAIT` after its last address;
- `ST_WAIT` goes to `ST_READY` when the timer expires.

Top module: `isp_serial_slave`

## Requirements
- R1: While `dev_rst` is high the link is inactive and `miso` is 0. Raising `dev_rst` in the middle of a frame discards the partial frame and clears the enabled state. Once `dev_rst` is low again, bit counting restarts at bit 0 of a new frame.
- R2: The enable frame is 0xAC 0x53 xx xx. During this frame the third byte returned on `miso` is 0x53. A frame starting 0xAC with any other second byte returns 0x00 in that slot and does not enable the block.
- R3: Before a successful enable, every erase, write, read and poll frame is ignored. No array write strobe fires, and the fourth returned byte is 0x00.
- R4: The erase frame is 0xAC 0x80 xx xx. It writes 0xFF to every address of both arrays, and the block then stays busy.
- R5: The data write frame is 0xC0 hi lo d. It stores d at address {hi,lo}, keeping only the low EE_AW bits. The store replaces the old byte completely, with no prior erase.
- R6: The data read frame is 0xA0 hi lo xx. It returns the byte at {hi,lo}, keeping only the low EE_AW bits, as the fourth returned byte.
- R7: The program write frame is 0x40 hi lo d. It stores d at program address {hi,lo}, keeping only the low PM_AW bits.
- R8: After a write completes, the block stays busy for BUSY_CYCLES system clocks. After an erase, it stays busy for the walk plus BUSY_CYCLES. Frames that arrive while busy are dropped, except the poll frame 0xF0 xx xx xx. The poll returns the busy flag in bit 0 of its fourth byte.
- R9: A frame with an unknown first byte changes no array. The next frame is still decoded from its first bit.
- R10: Serial clock half-periods of 4 system clocks are sampled without error.
- R11: `miso` changes only after a falling serial clock edge. Bytes are sent and received most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| dev_rst | input | 1 | Device reset input; the serial link is active while this is low |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data from the programmer |
| miso | output | 1 | Serial data to the programmer |
| pm_we | output | 1 | Program array write strobe |
| pm_addr | output | PM_AW | Program array address |
| pm_wdata | output | 8 | Program array write data |
| ee_we | output | 1 | Data array write strobe |
| ee_addr | output | EE_AW | Data array address, used for both read and write |
| ee_wdata | output | 8 | Data array write data |
| ee_rdata | input | 8 | Data array read data, valid one clock after the address |

## Verification
The hardest situation to reach is a second write frame that lands inside the busy window of the first. The programmer can only probe the window with the poll frame. The bench therefore makes the busy time longer than two frames. It sends a write, a poll and a conflicting write back to back, and then reads the address to show the conflicting write was dropped. The other hard case is abandoning the link in the middle of a frame. The bench stops after 13 bits and toggles `dev_rst`. It then shows that a write is refused until a fresh enable frame arrives, and that the enable frame decodes from its first bit.

// File: rtl/isp_pkg.sv
package isp_pkg;
    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 4;
    localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
    localparam int BCNT_W      = $clog2(FRAME_BITS);
    localparam int IDX_W       = $clog2(FRAME_BYTES);
    localparam int BIT_W       = $clog2(BYTE_W);

    localparam logic [7:0] OP_SYNC_HI  = 8'hAC;
    localparam logic [7:0] OP_SYNC_LO  = 8'h53;
    localparam logic [7:0] OP_WIPE_LO  = 8'h80;
    localparam logic [7:0] OP_EE_WR    = 8'hC0;
    localparam logic [7:0] OP_EE_RD    = 8'hA0;
    localparam logic [7:0] OP_PM_WR    = 8'h40;
    localparam logic [7:0] OP_POLL     = 8'hF0;
    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_LOCKED,
        ST_READY,
        ST_ERASE,
        ST_WAIT
    } isp_state_e;

    typedef enum logic [1:0] {
        RET_NONE,
        RET_READ,
        RET_POLL
    } ret_kind_e;
endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic mosi_in,
    input  logic devrst_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s,
    output logic active
);
    // bit 0 = serial clock, bit 1 = serial data, bit 2 = device reset
    logic [STAGES-1:0][2:0] chain;
    logic                   sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= 3'b100;
            sck_d <= 1'b0;
        end else begin
            chain[0] <= {devrst_in, mosi_in, sck_in};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            sck_d <= chain[STAGES-1][0];
        end
    end

    assign sck_rise = chain[STAGES-1][0] & ~sck_d;
    assign sck_fall = ~chain[STAGES-1][0] & sck_d;
    assign mosi_s   = chain[STAGES-1][1];
    assign active   = ~chain[STAGES-1][2];
endmodule

// File: rtl/isp_shifter.sv
module isp_shifter
    import isp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic [IDX_W-1:0]  byte_idx,
    output logic              miso
);
    logic [BCNT_W-1:0] bitcnt;
    logic [BYTE_W-2:0] rx;
    logic [BYTE_W-1:0] tx;

    assign byte_done = active & sck_rise & (&bitcnt[BIT_W-1:0]);
    assign byte_val  = {rx, mosi_s};
    assign byte_idx  = bitcnt[BCNT_W-1:BIT_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            rx     <= '0;
            tx     <= '0;
            miso   <= 1'b0;
        end else if (!active) begin
            bitcnt <= '0;
            rx     <= '0;
            tx     <= '0;
            miso   <= 1'b0;
        end else begin
            if (sck_rise) begin
                rx     <= {rx[BYTE_W-3:0], mosi_s};
                bitcnt <= bitcnt + 1'b1;
            end
            if (sck_fall) miso <= tx[BYTE_W-1];
            if (tx_load) begin
                tx <= tx_byte;
            end else if (sck_fall) begin
                tx <= {tx[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // R11
    miso_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !sck_fall) |=> $stable(miso));

    // R1
    miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (miso == 1'b0));
endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl
    import isp_pkg::*;
#(
    parameter int PM_AW       = 11,
    parameter int EE_AW       = 9,
    parameter int BUSY_CYCLES = 4500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic [7:0]        ee_rdata,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              pm_we,
    output logic [PM_AW-1:0]  pm_addr,
    output logic [7:0]        pm_wdata,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [7:0]        ee_wdata
);
    localparam int WW = (PM_AW > EE_AW) ? PM_AW : EE_AW;
    localparam int TW = $clog2(BUSY_CYCLES + 1);

    isp_state_e      state, state_nx;
    ret_kind_e       ret1, ret2;
    logic [7:0]      b0, b1;
    logic [WW-1:0]   walk;
    logic [TW-1:0]   timer;
    logic [15:0]     addr16;
    logic            frame_end, busy, pm_hit, ee_hit, walk_last, timer_last;

    assign frame_end  = byte_done && (byte_idx == IDX_W'(FRAME_BYTES - 1));
    assign busy       = (state == ST_ERASE) || (state == ST_WAIT);
    assign addr16     = {b1, byte_val};
    assign pm_hit     = ((walk >> PM_AW) == '0);
    assign ee_hit     = ((walk >> EE_AW) == '0);
    assign walk_last  = &walk;
    assign timer_last = (timer == TW'(BUSY_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:    if (active) state_nx = ST_LOCKED;
            ST_LOCKED: if (frame_end && b0 == OP_SYNC_HI && b1 == OP_SYNC_LO)
                           state_nx = ST_READY;
            ST_READY:  if (frame_end) begin
                           if (b0 == OP_SYNC_HI && b1 == OP_WIPE_LO) state_nx = ST_ERASE;
                           else if (b0 == OP_EE_WR || b0 == OP_PM_WR) state_nx = ST_WAIT;
                       end
            ST_ERASE:  if (walk_last) state_nx = ST_WAIT;
            ST_WAIT:   if (timer_last) state_nx = ST_READY;
        endcase
        if (!active) state_nx = ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_load <= 1'b0; tx_byte <= '0;
            pm_we <= 1'b0; pm_addr <= '0; pm_wdata <= '0;
            ee_we <= 1'b0; ee_addr <= '0; ee_wdata <= '0;
            ret1 <= RET_NONE; ret2 <= RET_NONE;
            b0 <= '0; b1 <= '0; walk <= '0; timer <= '0;
        end else begin
            pm_we   <= 1'b0;
            ee_we   <= 1'b0;
            tx_load <= 1'b0;
            ret1    <= RET_NONE;
            ret2    <= ret1;
            if (!active) begin
                b0 <= '0; b1 <= '0; ret2 <= RET_NONE; walk <= '0; timer <= '0;
            end else begin
                if (ret2 != RET_NONE) begin
                    tx_load <= 1'b1;
                    tx_byte <= (ret2 == RET_READ) ? ee_rdata : {7'b0, busy};
                end
                if (byte_done) begin
                    unique case (byte_idx)
                        2'd0: b0 <= byte_val;
                        2'd1: begin
                            b1 <= byte_val;
                            if (b0 == OP_SYNC_HI && byte_val == OP_SYNC_LO) begin
                                tx_load <= 1'b1;
                                tx_byte <= byte_val;
                            end
                        end
                        2'd2: begin
                            if (state == ST_READY) begin
                                pm_addr <= addr16[PM_AW-1:0];
                                ee_addr <= addr16[EE_AW-1:0];
                            end
                            if (b0 == OP_EE_RD && state == ST_READY) ret1 <= RET_READ;
                            else if (b0 == OP_POLL && (state == ST_READY || busy)) ret1 <= RET_POLL;
                        end
                        2'd3: if (state == ST_READY) begin
                            if (b0 == OP_EE_WR) begin ee_we <= 1'b1; ee_wdata <= byte_val; end
                            if (b0 == OP_PM_WR) begin pm_we <= 1'b1; pm_wdata <= byte_val; end
                        end
                    endcase
                end
                walk  <= (state == ST_ERASE) ? walk + 1'b1 : '0;
                timer <= (state == ST_WAIT) ? timer + 1'b1 : '0;
                if (state == ST_ERASE) begin
                    pm_we    <= pm_hit;
                    ee_we    <= ee_hit;
                    pm_addr  <= walk[PM_AW-1:0];
                    ee_addr  <= walk[EE_AW-1:0];
                    pm_wdata <= ERASED_BYTE;
                    ee_wdata <= ERASED_BYTE;
                end
            end
        end
    end

    // R1
    off_when_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (state == ST_OFF));

    // R3
    locked_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF || state == ST_LOCKED) |-> !(pm_we || ee_we));

    // R8
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && $past(state) == ST_WAIT) |-> !(pm_we || ee_we));

    // R4
    erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_ERASE && (pm_we || ee_we)) |->
            (pm_wdata == ERASED_BYTE && ee_wdata == ERASED_BYTE));
endmodule

// File: rtl/isp_serial_slave.sv
module isp_serial_slave
    import isp_pkg::*;
#(
    parameter int PM_AW       = 11,
    parameter int EE_AW       = 9,
    parameter int BUSY_CYCLES = 4500,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dev_rst,
    input  logic             sck,
    input  logic             mosi,
    output logic             miso,
    output logic             pm_we,
    output logic [PM_AW-1:0] pm_addr,
    output logic [7:0]       pm_wdata,
    output logic             ee_we,
    output logic [EE_AW-1:0] ee_addr,
    output logic [7:0]       ee_wdata,
    input  logic [7:0]       ee_rdata
);
    logic              sck_rise, sck_fall, mosi_s, active;
    logic              byte_done, tx_load;
    logic [BYTE_W-1:0] byte_val, tx_byte;
    logic [IDX_W-1:0]  byte_idx;

    isp_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .sck_in(sck), .mosi_in(mosi), .devrst_in(dev_rst),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s), .active(active)
    );

    isp_shifter shift_i (
        .clk(clk), .rst_n(rst_n), .active(active), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .mosi_s(mosi_s), .tx_load(tx_load), .tx_byte(tx_byte),
        .byte_done(byte_done), .byte_val(byte_val), .byte_idx(byte_idx), .miso(miso)
    );

    isp_ctrl #(.PM_AW(PM_AW), .EE_AW(EE_AW), .BUSY_CYCLES(BUSY_CYCLES)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .active(active), .byte_done(byte_done),
        .byte_val(byte_val), .byte_idx(byte_idx), .ee_rdata(ee_rdata),
        .tx_load(tx_load), .tx_byte(tx_byte),
        .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata)
    );
endmodule

// File: tb/isp_serial_slave_tb_top.sv
module isp_serial_slave_tb_top;
    localparam int PM_AW = 5;
    localparam int EE_AW = 4;
    localparam int BUSY  = 700;
    localparam int HALF  = 4;
    localparam int GAP   = BUSY + (1 << PM_AW) + 40;
    localparam int NVEC  = 9;

    // {frame, expected third returned byte, expected fourth returned byte}
    localparam logic [47:0] VEC [NVEC] = '{
        48'hAC530000_53_00,
        48'hC000035A_00_00,
        48'hA0000300_00_5A,
        48'hC00003A5_00_00,
        48'hA0000300_00_A5,
        48'h4000073C_00_00,
        48'h12345678_00_00,
        48'hA0000300_00_A5,
        48'hA0011300_00_A5
    };
    string row_tag [NVEC] = '{"R2 R10", "R5", "R6 R11", "R5", "R5 self-erase",
                              "R7", "R9", "R9 realign", "R5 R6 truncation"};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n, dev_rst, sck, mosi, miso;
    logic             pm_we, ee_we;
    logic [PM_AW-1:0] pm_addr;
    logic [EE_AW-1:0] ee_addr;
    logic [7:0]       pm_wdata, ee_wdata, ee_rdata;
    logic [7:0]       pm_mem [1 << PM_AW];
    logic [7:0]       ee_mem [1 << EE_AW];
    int               n_run = 0;
    int               n_fail = 0;
    logic [31:0]      rx;

    isp_serial_slave #(.PM_AW(PM_AW), .EE_AW(EE_AW), .BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .sck(sck), .mosi(mosi), .miso(miso),
        .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_rdata(ee_rdata)
    );

    always @(posedge clk) begin
        if (pm_we) pm_mem[pm_addr] <= pm_wdata;
        if (ee_we) ee_mem[ee_addr] <= ee_wdata;
        ee_rdata <= ee_mem[ee_addr];
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] w, input int nb, output logic [31:0] r);
        r = '0;
        for (int i = 0; i < nb; i++) begin
            mosi = w[31-i];
            repeat (HALF) @(negedge clk);
            r = {r[30:0], miso};
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic frame(input logic [31:0] w, output logic [31:0] r);
        send_bits(w, 32, r);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < (1 << PM_AW); i++) pm_mem[i] = 8'h00;
        for (int i = 0; i < (1 << EE_AW); i++) ee_mem[i] = 8'h00;
        ee_mem[5] = 8'h99;
        rst_n = 1'b0; dev_rst = 1'b1; sck = 1'b0; mosi = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1 reset miso", {31'b0, miso}, 0);
        check("R1 reset strobes", {30'b0, pm_we, ee_we}, 0);

        dev_rst = 1'b0;
        repeat (10) @(negedge clk);
        // R3: nothing works before enable
        frame(32'hC0000577, rx);
        repeat (GAP) @(negedge clk);
        check("R3 write before enable", {24'b0, ee_mem[5]}, 32'h99);
        frame(32'hA0000500, rx);
        check("R3 read before enable", {24'b0, rx[7:0]}, 0);
        frame(32'hAC800000, rx);
        repeat (GAP) @(negedge clk);
        check("R3 erase before enable", {24'b0, pm_mem[0]}, 0);
        // R2: wrong second byte gives no echo and no enable
        frame(32'hAC540000, rx);
        check("R2 bad sync echo", {24'b0, rx[15:8]}, 0);
        frame(32'hC0000577, rx);
        repeat (GAP) @(negedge clk);
        check("R2 bad sync stays locked", {24'b0, ee_mem[5]}, 32'h99);

        for (int v = 0; v < NVEC; v++) begin
            frame(VEC[v][47:16], rx);
            check({row_tag[v], " byte3"}, {24'b0, rx[15:8]}, {24'b0, VEC[v][15:8]});
            check({row_tag[v], " byte4"}, {24'b0, rx[7:0]}, {24'b0, VEC[v][7:0]});
            repeat (GAP) @(negedge clk);
        end
        check("R7 program byte", {24'b0, pm_mem[7]}, 32'h3C);
        check("R7 neighbour untouched", {24'b0, pm_mem[6]}, 0);
        check("R9 no stray write", {24'b0, ee_mem[6]}, 0);

        // R8: busy window drops writes, poll reports busy
        frame(32'hC0000211, rx);
        frame(32'hF0000000, rx);
        check("R8 poll busy", {24'b0, rx[7:0]}, 1);
        frame(32'hC0000222, rx);
        repeat (GAP) @(negedge clk);
        frame(32'hF0000000, rx);
        check("R8 poll idle", {24'b0, rx[7:0]}, 0);
        frame(32'hA0000200, rx);
        check("R8 dropped write", {24'b0, rx[7:0]}, 32'h11);

        // R4: chip erase fills both arrays
        frame(32'hAC800000, rx);
        frame(32'hF0000000, rx);
        check("R4 busy during erase", {24'b0, rx[7:0]}, 1);
        repeat (GAP) @(negedge clk);
        begin
            int bad = 0;
            for (int i = 0; i < (1 << PM_AW); i++) if (pm_mem[i] !== 8'hFF) bad++;
            for (int i = 0; i < (1 << EE_AW); i++) if (ee_mem[i] !== 8'hFF) bad++;
            check("R4 erased cells", bad, 0);
        end
        frame(32'hA0000500, rx);
        check("R4 read erased", {24'b0, rx[7:0]}, 32'hFF);

        // R1: abort mid-frame clears enable and realigns
        send_bits(32'hC0000444, 13, rx);
        dev_rst = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 miso idle", {31'b0, miso}, 0);
        dev_rst = 1'b0;
        repeat (10) @(negedge clk);
        frame(32'hC0000444, rx);
        repeat (GAP) @(negedge clk);
        check("R1 enable cleared", {24'b0, ee_mem[4]}, 32'hFF);
        frame(32'hAC530000, rx);
        check("R1 realigned echo", {24'b0, rx[15:8]}, 32'h53);
        frame(32'hC0000444, rx);
        repeat (GAP) @(negedge clk);
        check("R1 write after re-enable", {24'b0, ee_mem[4]}, 32'h44);

        finish_run();
    end
endmodule